// File: doc/BRIEF.md
# GPIO Pad Register Bank

This block holds the control state for a small group of general-purpose I/O pads and exposes it on a simple register bus. The bus addresses 32-bit words and completes each read or write in one cycle. Every pad owns a group of four words: a configuration word, two spare configuration words, and a value word. The group's position in the address map comes from a per-pad index parameter, not from the pad's position in the bank. The index is multiplied by a 16-byte stride. The value word carries the pad level and two active-low enables, one for the input and one for the output.

From this state the bank drives each pad's output and output enable, and it samples each pad's input into a register. The configuration word holds several fields: a function-select field, pull direction and strength, an open-drain selector, and four interrupt-trigger bits. The trigger bits are exported to a separate interrupt unit. A shared status word at a high offset lets software read that unit's pending flags. Writing ones to the status word sends a one-cycle clear strobe to the interrupt unit for the matching pads.

An address decode stage classifies each bus address into one of six selector values: configuration, spare word one, value, spare word two, status, or none. The read path and write path act on that selector. The bank has no sequencing state; every access finishes on the clock edge where it is presented.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset every value word reads 0x00000006 (both enables at 1, meaning disabled, and level 0), every configuration and spare word reads zero, no pad is driven, every trigger export is 0, and the clear strobe is 0.
- R2: A pad's register group starts at byte address index×16. The configuration word is at +0x0, spare word one at +0x4, the value word at +0x8 and spare word two at +0xC. The bus carries byte address / 4. With default parameters pad 0 uses index 0, pad 1 uses index 7, pad 2 uses index 2 and pad 3 uses index 5. The spare words store and return all 32 bits written to them.
- R3: Value word fields are: bit 0 level, bit 1 output enable (active low), bit 2 input enable (active low). Bits 31:3 read as zero. Bit 0 reads the pad input as registered one clock earlier while bit 2 is 0, and reads 0 while bit 2 is 1.
- R4: A pad is driven (pad_oe = 1) only when value bit 1 is 0 and configuration bits [2:0] equal 000. When the pad is driven in push-pull mode, pad_out equals the written level.
- R5: When configuration bit 31 (open-drain) is 1, the pad is driven low when the level is 0 and released (pad_oe = 0) when the level is 1.
- R6: Configuration bits 24, 25, 26 and 27 appear on trig_level, trig_rise, trig_fall and direct_irq for that pad. Each bit affects only its own pad.
- R7: The status word is at byte 0x800 (bus address 0x200). Reading it returns irq_pending in bits [NUM_PADS-1:0] and zero above. A write sets irq_clear to the written bits [NUM_PADS-1:0] for exactly the next cycle. Otherwise irq_clear is 0.
- R8: An address that matches no pad group and not the status word reads as zero. A write to such an address changes no pad register and no output.
- R9: Read data is registered. It appears in the cycle after bus_rd_en and holds until the next read. A write takes effect at the clock edge that samples it, so a read in the following cycle returns the new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr_en | input | 1 | Write strobe |
| bus_rd_en | input | 1 | Read strobe |
| bus_addr | input | 10 | Word address (byte address / 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 4 | Pad input levels |
| pad_out | output | 4 | Pad output levels |
| pad_oe | output | 4 | Pad output enables, active high |
| trig_level | output | 4 | Level-trigger selects to interrupt unit |
| trig_rise | output | 4 | Rising/high trigger selects |
| trig_fall | output | 4 | Falling/low trigger selects |
| direct_irq | output | 4 | Direct-interrupt enables |
| irq_pending | input | 4 | Pending flags from interrupt unit |
| irq_clear | output | 4 | One-cycle clear strobe to interrupt unit |

## Verification
The bench places pad groups out of order on purpose. A design that used the pad's position in the bank, instead of its index parameter, would return data from the wrong pad, or zero, at the mapped addresses. It also writes to the unmapped group index 1 and to the word just above the status word. A loose decoder would corrupt pad 0's value word or alias the status word, and the bench would see nonzero read data or a changed pad output.

The drive checks step through the cases that block driving: a nonzero function-select field, a disabled output, and open-drain mode with the level at 1. A design that inverted an active-low enable, or ignored open-drain mode, would drive the pad when it should be released. Input sampling is checked with the input enabled and with it disabled, and with set upper bits in the write data. A design that latched the written level into bit 0 would fail, and so would one that stored the upper bits. The clear strobe is checked on the cycle after the write and again one cycle later, which catches a strobe that sticks.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int WORD_W = 32;

    // configuration word bit positions
    localparam int CFG_MUX_LO   = 0;
    localparam int CFG_MUX_W    = 3;
    localparam int CFG_PULL_LO  = 7;
    localparam int CFG_STR_LO   = 9;
    localparam int CFG_TRIG_LVL = 24;
    localparam int CFG_TRIG_POS = 25;
    localparam int CFG_TRIG_NEG = 26;
    localparam int CFG_DIRECT   = 27;
    localparam int CFG_OPEN_DRN = 31;

    // value word bit positions
    localparam int VAL_LVL  = 0;
    localparam int VAL_OE_N = 1;
    localparam int VAL_IE_N = 2;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_CFG  = 3'd1,
        SEL_EXT1 = 3'd2,
        SEL_VAL  = 3'd3,
        SEL_EXT2 = 3'd4,
        SEL_STAT = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic ie_n;
        logic oe_n;
        logic lvl;
    } val_t;

    localparam val_t VAL_RESET = '{ie_n: 1'b1, oe_n: 1'b1, lvl: 1'b0};

endpackage

// File: rtl/gpb_addr_decode.sv
module gpb_addr_decode
    import gpb_pkg::*;
#(
    parameter int                      NUM_PADS = 4,
    parameter int                      IDX_W    = 4,
    parameter int                      ADDR_W   = 10,
    parameter logic [NUM_PADS*IDX_W-1:0] PAD_MAP = '0
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_PADS-1:0] pad_hit,
    output logic                stat_hit,
    output reg_sel_e            sel
);

    localparam int GRP_W = ADDR_W - 2;
    localparam logic [ADDR_W-1:0] STAT_WORD = ADDR_W'(1) << (ADDR_W - 1);

    logic [GRP_W-1:0] grp;
    assign grp = addr[ADDR_W-1:2];

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_hit
        logic [GRP_W-1:0] idx_ext;
        assign idx_ext    = {{(GRP_W-IDX_W){1'b0}}, PAD_MAP[i*IDX_W +: IDX_W]};
        assign pad_hit[i] = (grp == idx_ext);
    end

    assign stat_hit = (addr == STAT_WORD);

    always_comb begin
        sel = SEL_NONE;
        if (stat_hit) begin
            sel = SEL_STAT;
        end else if (|pad_hit) begin
            unique case (addr[1:0])
                2'd0: sel = SEL_CFG;
                2'd1: sel = SEL_EXT1;
                2'd2: sel = SEL_VAL;
                2'd3: sel = SEL_EXT2;
            endcase
        end
    end

endmodule

// File: rtl/gpb_pad_slice.sv
module gpb_pad_slice
    import gpb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [WORD_W-1:0] wdata,
    input  logic              pad_in,
    output logic [WORD_W-1:0] rd_word,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              trig_level,
    output logic              trig_rise,
    output logic              trig_fall,
    output logic              direct_irq
);

    logic [WORD_W-1:0] cfg_q;
    logic [WORD_W-1:0] ext1_q;
    logic [WORD_W-1:0] ext2_q;
    val_t              val_q;
    logic              samp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            ext1_q <= '0;
            ext2_q <= '0;
            val_q  <= VAL_RESET;
        end else if (wr_en) begin
            unique case (sel)
                SEL_CFG:  cfg_q  <= wdata;
                SEL_EXT1: ext1_q <= wdata;
                SEL_EXT2: ext2_q <= wdata;
                SEL_VAL: begin
                    val_q.lvl  <= wdata[VAL_LVL];
                    val_q.oe_n <= wdata[VAL_OE_N];
                    val_q.ie_n <= wdata[VAL_IE_N];
                end
                default: ;
            endcase
        end
    end

    // input sampler: gated by active-low input enable
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= val_q.ie_n ? 1'b0 : pad_in;
    end

    always_comb begin
        unique case (sel)
            SEL_CFG:  rd_word = cfg_q;
            SEL_EXT1: rd_word = ext1_q;
            SEL_EXT2: rd_word = ext2_q;
            SEL_VAL:  rd_word = {{(WORD_W-3){1'b0}}, val_q.ie_n, val_q.oe_n, samp_q};
            default:  rd_word = '0;
        endcase
    end

    logic mux_gpio;
    logic open_drn;
    assign mux_gpio = (cfg_q[CFG_MUX_LO +: CFG_MUX_W] == '0);
    assign open_drn = cfg_q[CFG_OPEN_DRN];

    assign pad_out    = open_drn ? 1'b0 : val_q.lvl;
    assign pad_oe     = !val_q.oe_n && mux_gpio && !(open_drn && val_q.lvl);
    assign trig_level = cfg_q[CFG_TRIG_LVL];
    assign trig_rise  = cfg_q[CFG_TRIG_POS];
    assign trig_fall  = cfg_q[CFG_TRIG_NEG];
    assign direct_irq = cfg_q[CFG_DIRECT];

    // R4
    oe_off_after_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_VAL && wdata[VAL_OE_N]) |=> !pad_oe);

    // R5
    open_drain_low_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe && open_drn) |-> !pad_out);

    // R3
    input_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        val_q.ie_n |=> !samp_q);

endmodule

// File: rtl/gpb_status.sv
module gpb_status
    import gpb_pkg::*;
#(
    parameter int NUM_PADS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [NUM_PADS-1:0] wbits,
    input  logic [NUM_PADS-1:0] pending,
    output logic [WORD_W-1:0]   rd_word,
    output logic [NUM_PADS-1:0] clear
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     clear <= '0;
        else if (wr_en) clear <= wbits;
        else            clear <= '0;
    end

    assign rd_word = {{(WORD_W-NUM_PADS){1'b0}}, pending};

    // R7
    clear_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (clear == $past(wbits)));

    // R7
    clear_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (clear == '0));

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
    import gpb_pkg::*;
#(
    parameter int                        NUM_PADS = 4,
    parameter int                        IDX_W    = 4,
    parameter int                        ADDR_W   = 10,
    parameter logic [NUM_PADS*IDX_W-1:0] PAD_MAP  = {4'd5, 4'd2, 4'd7, 4'd0}
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr_en,
    input  logic                bus_rd_en,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PADS-1:0] pad_in,
    output logic [NUM_PADS-1:0] pad_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [NUM_PADS-1:0] trig_level,
    output logic [NUM_PADS-1:0] trig_rise,
    output logic [NUM_PADS-1:0] trig_fall,
    output logic [NUM_PADS-1:0] direct_irq,
    input  logic [NUM_PADS-1:0] irq_pending,
    output logic [NUM_PADS-1:0] irq_clear
);

    logic [NUM_PADS-1:0] pad_hit;
    logic                stat_hit;
    reg_sel_e            sel;

    gpb_addr_decode #(
        .NUM_PADS (NUM_PADS),
        .IDX_W    (IDX_W),
        .ADDR_W   (ADDR_W),
        .PAD_MAP  (PAD_MAP)
    ) u_dec (
        .addr     (bus_addr),
        .pad_hit  (pad_hit),
        .stat_hit (stat_hit),
        .sel      (sel)
    );

    logic [WORD_W-1:0] pad_rd [NUM_PADS];

    for (genvar i = 0; i < NUM_PADS; i++) begin : g_pad
        gpb_pad_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (bus_wr_en && pad_hit[i]),
            .sel        (sel),
            .wdata      (bus_wdata),
            .pad_in     (pad_in[i]),
            .rd_word    (pad_rd[i]),
            .pad_out    (pad_out[i]),
            .pad_oe     (pad_oe[i]),
            .trig_level (trig_level[i]),
            .trig_rise  (trig_rise[i]),
            .trig_fall  (trig_fall[i]),
            .direct_irq (direct_irq[i])
        );
    end

    logic [WORD_W-1:0] stat_rd;

    gpb_status #(.NUM_PADS(NUM_PADS)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr_en && stat_hit),
        .wbits   (bus_wdata[NUM_PADS-1:0]),
        .pending (irq_pending),
        .rd_word (stat_rd),
        .clear   (irq_clear)
    );

    logic [WORD_W-1:0] rd_mux;
    always_comb begin
        rd_mux = stat_hit ? stat_rd : '0;
        for (int i = 0; i < NUM_PADS; i++) begin
            if (pad_hit[i]) rd_mux = rd_mux | pad_rd[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bus_rdata <= '0;
        else if (bus_rd_en) bus_rdata <= rd_mux;
    end

    // R2
    single_group_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pad_hit));

    // R8
    unmapped_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_en && sel == SEL_NONE) |=> (bus_rdata == '0));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_en |=> $stable(bus_rdata));

endmodule

// File: tb/tb_gpio_pad_bank.sv
`timescale 1ns/1ps
module tb_gpio_pad_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic        bus_rd_en = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pad_in = '0;
    logic [3:0]  pad_out, pad_oe, trig_level, trig_rise, trig_fall, direct_irq;
    logic [3:0]  irq_pending = '0;
    logic [3:0]  irq_clear;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    gpio_pad_bank dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_rd_en(bus_rd_en),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .trig_level(trig_level), .trig_rise(trig_rise), .trig_fall(trig_fall),
        .direct_irq(direct_irq), .irq_pending(irq_pending), .irq_clear(irq_clear)
    );

    // group index per pad, from R2
    function automatic logic [9:0] wa(int pad, int off);
        int g;
        case (pad)
            0: g = 0;
            1: g = 7;
            2: g = 2;
            default: g = 5;
        endcase
        return 10'(g * 4 + off);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [9:0] a, logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd_en = 1'b1;
        @(negedge clk);
        bus_rd_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin
            rd(wa(p, 2), d); chk("R1 value word", d, 32'h6);
            rd(wa(p, 0), d); chk("R1 cfg word", d, 32'h0);
            rd(wa(p, 3), d); chk("R1 spare word", d, 32'h0);
        end
        chk("R1 pad_oe", {28'h0, pad_oe}, 32'h0);
        chk("R1 triggers", {16'h0, trig_level, trig_rise, trig_fall, direct_irq}, 32'h0);
        chk("R1 irq_clear", {28'h0, irq_clear}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        for (int o = 0; o < 4; o++) wr(10'(4 + o), 32'hFFFF_FFFF);
        wr(10'h201, 32'hFFFF_FFFF);
        wr(10'd60, 32'hFFFF_FFFF);
        rd(10'd6, d);     chk("R8 unmapped group read", d, 32'h0);
        rd(10'h201, d);   chk("R8 above status read", d, 32'h0);
        rd(10'd60, d);    chk("R8 high group read", d, 32'h0);
        rd(wa(0, 2), d);  chk("R8 pad0 value untouched", d, 32'h6);
        rd(wa(0, 0), d);  chk("R8 pad0 cfg untouched", d, 32'h0);
        chk("R8 outputs untouched", {12'h0, pad_oe, trig_level, trig_rise, trig_fall, direct_irq}, 32'h0);
    endtask

    task automatic t_placement();
        logic [31:0] d;
        for (int p = 0; p < 4; p++) begin
            wr(wa(p, 1), 32'hA500_0000 | 32'(p << 8) | 32'h1);
            wr(wa(p, 3), 32'h5A00_0000 | 32'(p << 8) | 32'h3);
        end
        for (int p = 0; p < 4; p++) begin
            rd(wa(p, 1), d); chk("R2 spare word one", d, 32'hA500_0000 | 32'(p << 8) | 32'h1);
            rd(wa(p, 3), d); chk("R2 spare word two", d, 32'h5A00_0000 | 32'(p << 8) | 32'h3);
        end
    endtask

    task automatic t_input();
        logic [31:0] d;
        pad_in[0] = 1'b1;
        wr(wa(0, 2), 32'h2);
        repeat (2) @(negedge clk);
        rd(wa(0, 2), d); chk("R3 input sampled high", d, 32'h3);
        pad_in[0] = 1'b0;
        repeat (2) @(negedge clk);
        rd(wa(0, 2), d); chk("R3 input sampled low", d, 32'h2);
        pad_in[0] = 1'b1;
        wr(wa(0, 2), 32'h6);
        repeat (2) @(negedge clk);
        rd(wa(0, 2), d); chk("R3 input disabled reads 0", d, 32'h6);
        wr(wa(0, 2), 32'hFFFF_FFFA);
        repeat (2) @(negedge clk);
        rd(wa(0, 2), d); chk("R3 upper bits zero", d, 32'h3);
        pad_in[0] = 1'b0;
    endtask

    task automatic t_drive();
        wr(wa(2, 2), 32'h1);
        chk("R4 pad2 driven", {31'h0, pad_oe[2]}, 32'h1);
        chk("R4 pad2 level", {31'h0, pad_out[2]}, 32'h1);
        chk("R4 only pad2 driven", {28'h0, pad_oe}, 32'h4);
        wr(wa(2, 0), 32'h1);
        chk("R4 mux nonzero releases", {31'h0, pad_oe[2]}, 32'h0);
        wr(wa(2, 0), 32'h0);
        chk("R4 mux zero drives", {31'h0, pad_oe[2]}, 32'h1);
        wr(wa(2, 2), 32'h0);
        chk("R4 level 0", {31'h0, pad_out[2]}, 32'h0);
        wr(wa(2, 2), 32'h3);
        chk("R4 output disabled", {31'h0, pad_oe[2]}, 32'h0);
    endtask

    task automatic t_open_drain();
        wr(wa(3, 0), 32'h8000_0000);
        wr(wa(3, 2), 32'h0);
        chk("R5 open drain low drives", {30'h0, pad_oe[3], pad_out[3]}, 32'h2);
        wr(wa(3, 2), 32'h1);
        chk("R5 open drain high releases", {31'h0, pad_oe[3]}, 32'h0);
        chk("R5 bit31 not a trigger", {28'h0, trig_level[3], trig_rise[3], trig_fall[3], direct_irq[3]}, 32'h0);
    endtask

    task automatic t_trig();
        wr(wa(1, 0), 32'h0F00_0000);
        chk("R6 all triggers pad1", {16'h0, trig_level, trig_rise, trig_fall, direct_irq}, 32'h2222);
        wr(wa(1, 0), 32'h0200_0000);
        chk("R6 rise only", {16'h0, trig_level, trig_rise, trig_fall, direct_irq}, 32'h0200);
        wr(wa(1, 0), 32'h0100_0000);
        chk("R6 level only", {16'h0, trig_level, trig_rise, trig_fall, direct_irq}, 32'h2000);
    endtask

    task automatic t_status();
        logic [31:0] d;
        irq_pending = 4'b1010;
        rd(10'h200, d); chk("R7 status read", d, 32'hA);
        wr(10'h200, 32'hFFFF_FFF6);
        chk("R7 clear strobe", {28'h0, irq_clear}, 32'h6);
        @(negedge clk);
        chk("R7 clear one cycle", {28'h0, irq_clear}, 32'h0);
        irq_pending = 4'b0;
    endtask

    task automatic t_timing();
        logic [31:0] d;
        wr(wa(1, 1), 32'h1234_5678);
        rd(wa(1, 1), d); chk("R9 read after write", d, 32'h1234_5678);
        repeat (3) @(negedge clk);
        chk("R9 rdata holds", bus_rdata, 32'h1234_5678);
        @(negedge clk);
        bus_addr = wa(1, 3); bus_rd_en = 1'b1;
        #1;
        chk("R9 rdata not combinational", bus_rdata, 32'h1234_5678);
        @(negedge clk);
        bus_rd_en = 1'b0;
        chk("R9 rdata next cycle", bus_rdata, 32'h5A00_0103);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unmapped();
        t_placement();
        t_input();
        t_drive();
        t_open_drain();
        t_trig();
        t_status();
        t_timing();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule